// File: doc/BRIEF.md
# Glitchless Divided Clock Selector

This block produces the clock for one subsystem. The clock comes either from a fast source, divided by a power of two, or from a slow source. Software writes three register fields into the block: a source code, a divider code and a powerdown clock code. The subsystem adds a powerdown request line. While that request is high and the fast source is the selected one, the block swaps the output to the configured powerdown clock, which is the slow clock or no clock at all. It returns to the divided fast clock by itself once the request drops.

Every handover is break-before-make. The old clock is switched off while it is low. The output then sits low with no source. The new clock is switched on while it is low, after its own synchroniser has seen the request. A two-bit status shows which clock actually drives the output, and it changes only when the gating of a branch changes. The control logic runs on the slow, always-on clock. Each clock branch has its own two-flop synchroniser.

Top module: `dclk_selector`

## Requirements
- R1: Divider code N (0..7) makes the fast-branch output period 2^(N+1) fast-clock cycles, with a high phase of 2^N fast cycles. The divider code resets to 0.
- R2: Source code 1 selects the divided fast clock and source code 4 selects the slow clock. The selection resets to the fast clock. While the slow clock is active, the output is high whenever the slow clock is high.
- R3: Handover is break-before-make, so both bits of the status are never 1 together. The status changes only to or from 00. Every high pulse on the output is a complete high phase of one source.
- R4: While powerdown is requested and the fast clock is the selected source, powerdown code 1 gives the slow clock. Codes 0, 2 and 3 give no clock, with the output held low and the status 00.
- R5: When the powerdown request drops, the output goes back to the divided fast clock without any new source write.
- R6: A powerdown request has no effect while the slow clock is the selected source.
- R7: A change of the divider code while the fast branch is active is held back. It takes effect once the fast branch has been switched off.
- R8: Source codes other than 1 and 4 are ignored, and the previous selection stays.
- R9: The status reads 00 for no clock, 01 for the fast branch and 10 for the slow clock. During reset the status is 00 and the output is low.

Ports (all inputs are assumed to be held stable for several slow-clock cycles):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hf | input | 1 | Fast source clock |
| clk_lf | input | 1 | Slow, always-running source clock; clocks the control logic |
| rst | input | 1 | Synchronous active-high reset, held for at least two slow-clock cycles |
| cfg_src | input | 3 | Source code: 1 selects the fast clock, 4 selects the slow clock |
| cfg_div | input | DIV_W | Fast-clock divider code N, dividing by 2^(N+1) |
| cfg_pd_src | input | 2 | Powerdown clock code: 1 selects the slow clock, any other value selects no clock |
| pd_req | input | 1 | Powerdown request from the subsystem |
| clk_out | output | 1 | Gated output clock |
| act_src | output | 2 | Active source: 00 none, 01 fast branch, 10 slow clock |

## Verification
A handover state that goes wrong appears at the ports in one of two ways. A short high pulse appears on clk_out, or act_src shows 11 or jumps between 01 and 10 without passing 00, within a cycle of the faulty enable. The bench measures the width of every high pulse against the legal half-periods. A wrong target or a wrong divider latch shows up as a wrong status or a wrong period once the handover has settled. The bench reads both a few hundred fast cycles after each change.

// File: rtl/dclk_pkg.sv
`timescale 1ns/1ps
package dclk_pkg;

    localparam int SRC_CODE_W = 3;
    localparam int PDS_CODE_W = 2;
    localparam int DIV_CODE_W = 3;
    localparam int SYNC_DEPTH = 2;

    localparam logic [SRC_CODE_W-1:0] SRC_CODE_HF = 3'd1;
    localparam logic [SRC_CODE_W-1:0] SRC_CODE_LF = 3'd4;
    localparam logic [PDS_CODE_W-1:0] PDS_CODE_LF = 2'd1;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_HF   = 2'd1,
        CK_LF   = 2'd2
    } ck_src_e;

    typedef struct packed {
        logic    known;
        ck_src_e src;
    } src_dec_t;

    function automatic src_dec_t decode_src(logic [SRC_CODE_W-1:0] code);
        src_dec_t d;
        d.known = 1'b0;
        d.src   = CK_NONE;
        if (code == SRC_CODE_HF) begin
            d.known = 1'b1;
            d.src   = CK_HF;
        end else if (code == SRC_CODE_LF) begin
            d.known = 1'b1;
            d.src   = CK_LF;
        end
        return d;
    endfunction

    function automatic ck_src_e pd_pick(logic [PDS_CODE_W-1:0] code);
        return (code == PDS_CODE_LF) ? CK_LF : CK_NONE;
    endfunction

    function automatic ck_src_e resolve_goal(ck_src_e sel, logic pd,
                                             logic [PDS_CODE_W-1:0] pds);
        if (sel == CK_HF && pd)
            return pd_pick(pds);
        return sel;
    endfunction

    function automatic ck_src_e step_toward(ck_src_e cur, ck_src_e goal);
        return (cur == CK_NONE) ? goal : CK_NONE;
    endfunction

endpackage

// File: rtl/dclk_hf_div.sv
`timescale 1ns/1ps
module dclk_hf_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk_hf,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_code,
    input  logic             hold,
    output logic             clk_div
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] code_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_lim;
    logic             div_q;
    logic             reload;

    assign half_lim = (CNT_W'(1) << code_q) - CNT_W'(1);
    assign reload   = !hold && (div_code != code_q);

    always_ff @(posedge clk_hf) begin
        if (rst) begin
            code_q <= '0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (reload) begin
            code_q <= div_code;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (cnt_q == half_lim) begin
            cnt_q  <= '0;
            div_q  <= ~div_q;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign clk_div = div_q;
endmodule

// File: rtl/dclk_gate_branch.sv
`timescale 1ns/1ps
module dclk_gate_branch #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic edge_ok,
    output logic en_o,
    output logic idle_o
);
    logic [SYNC_N-1:0] sync_q;
    logic              en_q;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_N-2:0], want};
    end

    always_ff @(negedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (edge_ok)
            en_q <= sync_q[SYNC_N-1];
    end

    assign en_o   = en_q;
    assign idle_o = ~(|sync_q) & ~en_q;
endmodule

// File: rtl/dclk_ctrl.sv
`timescale 1ns/1ps
module dclk_ctrl
    import dclk_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic                  clk_lf,
    input  logic                  rst,
    input  logic [SRC_CODE_W-1:0] cfg_src,
    input  logic [PDS_CODE_W-1:0] cfg_pd_src,
    input  logic                  pd_req,
    input  logic                  hf_en_async,
    input  logic                  lf_en,
    input  logic                  lf_idle,
    output logic                  want_hf_o,
    output logic                  want_lf_o
);
    logic [SYNC_N-1:0] pd_s;
    logic [SYNC_N-1:0] hfen_s;
    ck_src_e           sel_q;
    ck_src_e           tgt_q;
    ck_src_e           sel_nx;
    ck_src_e           goal;
    ck_src_e           tgt_nx;
    src_dec_t          dec;
    logic              hf_seen;
    logic              settled;
    logic              want_hf_q;
    logic              want_lf_q;

    always_comb begin
        dec     = decode_src(cfg_src);
        sel_nx  = dec.known ? dec.src : sel_q;
        goal    = resolve_goal(sel_q, pd_s[SYNC_N-1], cfg_pd_src);
        hf_seen = hfen_s[SYNC_N-1];
        settled = (hf_seen == (tgt_q == CK_HF)) &&
                  ((tgt_q == CK_LF) ? lf_en : lf_idle);
        tgt_nx  = (settled && goal != tgt_q) ? step_toward(tgt_q, goal) : tgt_q;
    end

    always_ff @(posedge clk_lf) begin
        if (rst) begin
            pd_s      <= '0;
            hfen_s    <= '0;
            sel_q     <= CK_HF;
            tgt_q     <= CK_NONE;
            want_hf_q <= 1'b0;
            want_lf_q <= 1'b0;
        end else begin
            pd_s      <= {pd_s[SYNC_N-2:0], pd_req};
            hfen_s    <= {hfen_s[SYNC_N-2:0], hf_en_async};
            sel_q     <= sel_nx;
            tgt_q     <= tgt_nx;
            want_hf_q <= (tgt_nx == CK_HF);
            want_lf_q <= (tgt_nx == CK_LF);
        end
    end

    assign want_hf_o = want_hf_q;
    assign want_lf_o = want_lf_q;
endmodule

// File: rtl/dclk_selector.sv
`timescale 1ns/1ps
module dclk_selector
    import dclk_pkg::*;
#(
    parameter int DIV_W  = DIV_CODE_W,
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic                  clk_hf,
    input  logic                  clk_lf,
    input  logic                  rst,
    input  logic [SRC_CODE_W-1:0] cfg_src,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [PDS_CODE_W-1:0] cfg_pd_src,
    input  logic                  pd_req,
    output logic                  clk_out,
    output logic [1:0]            act_src
);
    logic hf_div;
    logic want_hf;
    logic want_lf;
    logic en_hf;
    logic en_lf;
    logic idle_hf;
    logic idle_lf;

    dclk_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
        .clk_lf      (clk_lf),
        .rst         (rst),
        .cfg_src     (cfg_src),
        .cfg_pd_src  (cfg_pd_src),
        .pd_req      (pd_req),
        .hf_en_async (en_hf),
        .lf_en       (en_lf),
        .lf_idle     (idle_lf),
        .want_hf_o   (want_hf),
        .want_lf_o   (want_lf)
    );

    dclk_hf_div #(.DIV_W(DIV_W)) u_div (
        .clk_hf   (clk_hf),
        .rst      (rst),
        .div_code (cfg_div),
        .hold     (!idle_hf),
        .clk_div  (hf_div)
    );

    dclk_gate_branch #(.SYNC_N(SYNC_N)) u_br_hf (
        .clk     (clk_hf),
        .rst     (rst),
        .want    (want_hf),
        .edge_ok (!hf_div),
        .en_o    (en_hf),
        .idle_o  (idle_hf)
    );

    dclk_gate_branch #(.SYNC_N(SYNC_N)) u_br_lf (
        .clk     (clk_lf),
        .rst     (rst),
        .want    (want_lf),
        .edge_ok (1'b1),
        .en_o    (en_lf),
        .idle_o  (idle_lf)
    );

    assign clk_out = (hf_div & en_hf) | (clk_lf & en_lf);
    assign act_src = {en_lf, en_hf};
endmodule

// File: rtl/dclk_selector_chk.sv
`timescale 1ns/1ps
module dclk_selector_chk (
    input logic       clk_hf,
    input logic       clk_lf,
    input logic       rst,
    input logic       clk_out,
    input logic [1:0] act_src
);
    AST_ONE_SOURCE: assert property (@(posedge clk_hf) disable iff (rst)
        act_src != 2'b11); // R3

    AST_PASS_THROUGH_NONE: assert property (@(posedge clk_hf) disable iff (rst)
        (act_src != $past(act_src)) |-> ($past(act_src) == 2'b00 || act_src == 2'b00)); // R3

    AST_QUIET_WHEN_NONE: assert property (@(posedge clk_hf) disable iff (rst)
        (act_src == 2'b00) |-> !clk_out); // R4

    AST_LF_FOLLOWS: assert property (@(negedge clk_lf) disable iff (rst)
        (act_src == 2'b10) |-> clk_out); // R2
endmodule

bind dclk_selector dclk_selector_chk u_chk (
    .clk_hf  (clk_hf),
    .clk_lf  (clk_lf),
    .rst     (rst),
    .clk_out (clk_out),
    .act_src (act_src)
);

// File: tb/sim_dclk_selector.sv
`timescale 1ns/1ps
module sim_dclk_selector;
    logic       clk_hf = 1'b0;
    logic       clk_lf = 1'b0;
    logic       rst    = 1'b1;
    logic [2:0] cfg_src = 3'd1;
    logic [2:0] cfg_div = 3'd0;
    logic [1:0] cfg_pd_src = 2'd0;
    logic       pd_req = 1'b0;
    logic       clk_out;
    logic [1:0] act_src;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    realtime t_prev = 0.0, t_last = 0.0;
    int      rise_cnt  = 0;
    int      pulse_bad = 0;
    int      bad_width = 0;

    // model state
    int prev_exp  = 0;   // 0 none, 1 hf, 2 lf
    int sel_model = 1;
    int div_model = 0;

    dclk_selector u0 (
        .clk_hf(clk_hf), .clk_lf(clk_lf), .rst(rst),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_pd_src(cfg_pd_src),
        .pd_req(pd_req), .clk_out(clk_out), .act_src(act_src)
    );

    always #4 clk_hf = ~clk_hf;                 // 125 MHz
    initial begin
        #2;
        forever #48 clk_lf = ~clk_lf;           // slow clock, 96 ns period
    end

    function automatic bit legal_high(int w_ps);
        if (w_ps == 48000) return 1'b1;
        for (int k = 0; k < 8; k++)
            if (w_ps == (8000 << k)) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk_out) begin
        t_prev = t_last;
        t_last = $realtime;
        rise_cnt++;
    end

    always @(negedge clk_out) begin
        int w;
        w = int'(($realtime - t_last) * 1000.0);
        if (!rst && !legal_high(w)) begin
            pulse_bad++;
            bad_width = w;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_source(int sel, bit pd, int pds);
        if (sel == 1 && pd) return (pds == 1) ? 2 : 0;
        return sel;
    endfunction

    task automatic trial(int src, int div, int pds, bit pd, string req);
        int exp;
        int per_ps;
        @(negedge clk_hf);
        cfg_src = 3'(src); cfg_div = 3'(div); cfg_pd_src = 2'(pds); pd_req = pd;
        if (src == 1) sel_model = 1;
        else if (src == 4) sel_model = 2;
        exp = exp_source(sel_model, pd, pds);
        if (prev_exp != 1) div_model = div;
        pulse_bad = 0;
        repeat (800) @(posedge clk_hf);
        @(negedge clk_hf);
        chk(pulse_bad == 0, "R3", {req, " high pulse width ps"}, bad_width, 0);
        chk(act_src == 2'(exp), "R9", {req, " status"}, int'(act_src), exp);
        rise_cnt = 0;
        repeat (1100) @(posedge clk_hf);
        @(negedge clk_hf);
        if (exp == 0) begin
            chk(rise_cnt == 0, "R4", {req, " rising edges with no clock"}, rise_cnt, 0);
        end else begin
            per_ps = (exp == 1) ? (16000 << div_model) : 96000;
            chk(rise_cnt >= 2, req, "edge count", rise_cnt, 2);
            chk(int'((t_last - t_prev) * 1000.0) == per_ps, req, "period ps",
                int'((t_last - t_prev) * 1000.0), per_ps);
        end
        prev_exp = exp;
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4242);
        repeat (20) @(posedge clk_hf);
        @(negedge clk_hf);
        chk(act_src == 2'b00, "R9", "status in reset", int'(act_src), 0);
        chk(clk_out == 1'b0, "R9", "output in reset", int'(clk_out), 0);
        repeat (10) @(posedge clk_hf);
        @(negedge clk_hf);
        rst = 1'b0;

        trial(1, 0, 0, 0, "R1");   // reset divider, fast/2
        trial(1, 3, 0, 0, "R7");   // divider change held while fast active
        trial(4, 3, 0, 0, "R2");   // slow clock
        trial(1, 3, 0, 0, "R1");   // new divider applied: /16
        trial(1, 7, 0, 0, "R7");   // held again
        trial(4, 7, 0, 0, "R2");
        trial(1, 7, 0, 0, "R1");   // /256
        trial(6, 7, 0, 0, "R8");   // unsupported code ignored
        trial(1, 7, 1, 1, "R4");   // powerdown to slow clock
        trial(1, 7, 1, 0, "R5");   // back to fast
        trial(1, 7, 0, 1, "R4");   // powerdown to no clock
        trial(1, 2, 3, 1, "R4");   // code 3 is no clock
        trial(1, 2, 0, 0, "R5");   // back to fast, /8
        trial(4, 2, 1, 1, "R6");   // powerdown with slow selected
        trial(4, 2, 0, 1, "R6");
        trial(0, 5, 0, 1, "R8");   // code 0 ignored

        for (int i = 0; i < 24; i++) begin
            int r, s;
            r = int'($urandom % 8);
            if (r < 3) s = 1;
            else if (r < 6) s = 4;
            else s = int'($urandom % 8);
            trial(s, int'($urandom % 8), int'($urandom % 4), bit'($urandom % 2),
                  (s == 1) ? "R1" : (s == 4) ? "R2" : "R8");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_hf);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule